// File: doc/BRIEF.md
# RMII Transmit Di-bit to 4B/5B Symbol Encoder

This block sits on the transmit side of a 100 Mb/s physical-layer data path. A MAC presents two data bits and an enable on each rising edge of a shared reference clock. The block pairs consecutive di-bits into 4-bit nibbles and turns each nibble into a 5-bit code group. It replaces the first preamble octet with the start-of-stream pair and closes every packet with the end-of-stream pair. Between packets it sends idle code groups. The output is a registered 5-bit symbol and a one-cycle strobe, which fires at most once every two clock cycles.

Packet framing comes only from the enable edges. A rise of the enable while the block is idle opens a packet, and the di-bit sampled in that same cycle is the first one. A fall closes the packet. The reduced interface has no flow control, so neither side can apply back-pressure. The symbol and its strobe are a push-only stream: the consumer must take each symbol in the cycle its strobe is high. The input side likewise accepts one di-bit per clock without stalling.

Top module: `rmii_tx_symbolizer`

## Requirements
- R1: While reset is asserted, `sym_valid` is low and `sym_out` holds idle (11111). After reset is released, the first idle strobe comes on the second rising edge. While no packet is in progress, an idle strobe follows every two cycles.
- R2: `sym_valid` is high for one cycle at a time and is never high on two consecutive cycles.
- R3: A packet starts in a cycle where `tx_en` is sampled high after being low in the previous cycle, provided the block is idle. The di-bit of that cycle is the first di-bit of the packet. Its first symbol is strobed one cycle after the cycle that completes the first nibble.
- R4: Two consecutive di-bits form one nibble. The earlier di-bit gives nibble bits [1:0] and the later di-bit gives bits [3:2].
- R5: The first two nibbles of a packet are sent as J (11000) and then K (10001), whatever their data. Every later nibble is sent as its data code group.
- R6: Data nibbles 0 to F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R7: After `tx_en` falls, the block sends T (01101) and then R (00111), two cycles apart, and then returns to idle strobes.
- R8: If a packet holds an odd number of di-bits, the last di-bit is padded with 00 in bits [3:2]. The resulting nibble is coded like any other nibble, including J or K when it is one of the first two.
- R9: A rise of `tx_en` before R has been sent does not start a packet. That packet is dropped until `tx_en` has been low in an idle cycle and rises again.
- R10: `txd` has no effect on the output while no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC; high for the whole packet |
| txd | input | 2 | Transmit di-bit from the MAC |
| sym_out | output | 5 | Current 5-bit code group |
| sym_valid | output | 1 | One-cycle strobe; `sym_out` is new in this cycle |

## Verification
The bench goes after the pairing order. It sends a packet whose nibbles walk through every value, so a design that swapped the di-bits would produce the code group of a different nibble and not match. Packets of one, three and seven di-bits probe the padding path. A design that dropped the lone di-bit, or padded the wrong half, would skip a symbol or emit the wrong one before T. Enable is raised again during the T/R tail and at both idle phases. A design that reopened a packet from the tail, or lost alignment at the start, would strobe J at the wrong time or place strobes back to back. Random values on `txd` while idle expose a design that leaks di-bits into the idle stream.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  localparam int DIBIT_W = 2;
  localparam int NIB_W   = 2 * DIBIT_W;
  localparam int SYM_W   = 5;
  localparam int IDX_W   = 2;

  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_END_T = 2'd2,
    ST_END_R = 2'd3
  } rtx_state_e;
endpackage

// File: rtl/rtx_code_map.sv
module rtx_code_map
  import rtx_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SYM_W-1:0] code_o
);
  always_comb begin
    case (nib_i)
      4'h0: code_o = 5'b11110;
      4'h1: code_o = 5'b01001;
      4'h2: code_o = 5'b10100;
      4'h3: code_o = 5'b10101;
      4'h4: code_o = 5'b01010;
      4'h5: code_o = 5'b01011;
      4'h6: code_o = 5'b01110;
      4'h7: code_o = 5'b01111;
      4'h8: code_o = 5'b10010;
      4'h9: code_o = 5'b10011;
      4'hA: code_o = 5'b10110;
      4'hB: code_o = 5'b10111;
      4'hC: code_o = 5'b11010;
      4'hD: code_o = 5'b11011;
      4'hE: code_o = 5'b11100;
      default: code_o = 5'b11101;
    endcase
  end
endmodule

// File: rtl/rtx_en_edge.sv
module rtx_en_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rise_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  assign rise_o = en_i & ~en_q;
endmodule

// File: rtl/rtx_nib_pairer.sv
module rtx_nib_pairer
  import rtx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_lo,
  input  logic               use_hi,
  input  logic [DIBIT_W-1:0] dibit_i,
  output logic [NIB_W-1:0]   nib_o
);
  logic [DIBIT_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (load_lo) lo_q <= dibit_i;
  end

  // Later di-bit supplies the upper half; a missing one pads with zeros.
  assign nib_o = use_hi ? {dibit_i, lo_q} : {{DIBIT_W{1'b0}}, lo_q};
endmodule

// File: rtl/rmii_tx_symbolizer.sv
module rmii_tx_symbolizer
  import rtx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [DIBIT_W-1:0] txd,
  output logic [SYM_W-1:0]   sym_out,
  output logic               sym_valid
);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(2);

  rtx_state_e          st_q, st_d;
  logic                half_q, half_d;
  logic [IDX_W-1:0]    idx_q;
  logic                idx_clr, idx_inc;
  logic                load_lo;
  logic                emit;
  logic [SYM_W-1:0]    emit_sym;
  logic                en_rise;
  logic [NIB_W-1:0]    nib;
  logic [SYM_W-1:0]    data_code;
  logic [SYM_W-1:0]    frame_code;
  logic [SYM_W-1:0]    sym_q;
  logic                val_q;

  rtx_en_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (tx_en),
    .rise_o (en_rise)
  );

  rtx_nib_pairer u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_lo (load_lo),
    .use_hi  (tx_en),
    .dibit_i (txd),
    .nib_o   (nib)
  );

  rtx_code_map u_map (
    .nib_i  (nib),
    .code_o (data_code)
  );

  always_comb begin
    if (idx_q == '0)             frame_code = SYM_J;
    else if (idx_q == IDX_W'(1)) frame_code = SYM_K;
    else                         frame_code = data_code;
  end

  always_comb begin
    st_d     = st_q;
    half_d   = ~half_q;
    emit     = 1'b0;
    emit_sym = SYM_IDLE;
    load_lo  = 1'b0;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_rise) begin
          st_d    = ST_DATA;
          load_lo = 1'b1;
          half_d  = 1'b1;
          idx_clr = 1'b1;
        end else if (half_q) begin
          emit     = 1'b1;
          emit_sym = SYM_IDLE;
        end
      end
      ST_DATA: begin
        if (half_q) begin
          emit     = 1'b1;
          emit_sym = frame_code;
          half_d   = 1'b0;
          if (tx_en) idx_inc = 1'b1;
          else       st_d    = ST_END_T;
        end else if (tx_en) begin
          load_lo = 1'b1;
          half_d  = 1'b1;
        end else begin
          st_d   = ST_END_T;
          half_d = 1'b1;
        end
      end
      ST_END_T: begin
        if (half_q) begin
          emit     = 1'b1;
          emit_sym = SYM_T;
          st_d     = ST_END_R;
        end
      end
      default: begin
        if (half_q) begin
          emit     = 1'b1;
          emit_sym = SYM_R;
          st_d     = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      idx_q  <= '0;
      sym_q  <= SYM_IDLE;
      val_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      if (idx_clr)                         idx_q <= '0;
      else if (idx_inc && idx_q != IDX_DATA) idx_q <= idx_q + IDX_W'(1);
      val_q <= emit;
      if (emit) sym_q <= emit_sym;
    end
  end

  assign sym_out   = sym_q;
  assign sym_valid = val_q;
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker
  import rtx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SYM_W-1:0] sym_out,
  input logic             sym_valid
);
  logic [SYM_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= SYM_IDLE;
    else if (sym_valid) last_q <= sym_out;
  end

  function automatic logic is_legal(input logic [SYM_W-1:0] s);
    case (s)
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101,
      5'b11000, 5'b10001, 5'b01101, 5'b00111, 5'b11111: is_legal = 1'b1;
      default: is_legal = 1'b0;
    endcase
  endfunction

  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> is_legal(sym_out));

  p_j_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_out == SYM_J) |-> (last_q == SYM_IDLE || last_q == SYM_R));

  p_k_after_j_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_out == SYM_K) |-> (last_q == SYM_J));

  p_t_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_out == SYM_T) |->
      (last_q != SYM_IDLE && last_q != SYM_T && last_q != SYM_R));

  p_r_after_t_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_out == SYM_R) |-> (last_q == SYM_T));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> (sym_valid || $stable(sym_out)));
endmodule

bind rmii_tx_symbolizer rtx_checker u_rtx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_out   (sym_out),
  .sym_valid (sym_valid)
);

// File: tb/rmii_tx_symbolizer_bench.sv
module rmii_tx_symbolizer_bench;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] txd = 2'b00;
  logic [4:0] sym_out;
  logic       sym_valid;

  rmii_tx_symbolizer u_rmii_tx_symbolizer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .txd       (txd),
    .sym_out   (sym_out),
    .sym_valid (sym_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // Behavioural reference: mode 0 idle, 1 packet, 2 tail
  int         m_mode = 0;
  bit         m_slot = 0;
  bit         m_prev_en = 0;
  int         m_nib = 0;
  int         m_dq[$];
  logic [4:0] m_tail[$];
  logic       exp_v = 1'b0;
  logic [4:0] exp_s = 5'b11111;
  logic       prev_v = 1'b0;

  function automatic logic [4:0] ref_code(input int n);
    logic [4:0] c;
    case (n)
      0: c = 5'b11110;  1: c = 5'b01001;  2: c = 5'b10100;  3: c = 5'b10101;
      4: c = 5'b01010;  5: c = 5'b01011;  6: c = 5'b01110;  7: c = 5'b01111;
      8: c = 5'b10010;  9: c = 5'b10011; 10: c = 5'b10110; 11: c = 5'b10111;
      12: c = 5'b11010; 13: c = 5'b11011; 14: c = 5'b11100; default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic [4:0] framed(input int idx, input int value);
    if (idx == 0) return 5'b11000;
    if (idx == 1) return 5'b10001;
    return ref_code(value);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_slot = 0; m_prev_en = 0; m_nib = 0;
      m_dq.delete(); m_tail.delete();
      exp_v = 1'b0; exp_s = 5'b11111;
    end else begin
      exp_v = 1'b0;
      if (m_mode == 0) begin
        if (tx_en && !m_prev_en) begin
          m_mode = 1; m_nib = 0; m_dq.delete(); m_dq.push_back(int'(txd));
        end else begin
          if (m_slot) begin exp_v = 1'b1; exp_s = 5'b11111; end
          m_slot = !m_slot;
        end
      end else if (m_mode == 1) begin
        if (tx_en) begin
          m_dq.push_back(int'(txd));
          if (m_dq.size() == 2) begin
            exp_v = 1'b1;
            exp_s = framed(m_nib, m_dq[0] + 4 * m_dq[1]);
            m_nib++;
            m_dq.delete();
          end
        end else begin
          if (m_dq.size() == 1) begin
            exp_v = 1'b1;
            exp_s = framed(m_nib, m_dq[0]);
            m_slot = 0;
          end else begin
            m_slot = 1;
          end
          m_dq.delete();
          m_tail.push_back(5'b01101);
          m_tail.push_back(5'b00111);
          m_mode = 2;
        end
      end else begin
        if (m_slot) begin
          exp_v = 1'b1;
          exp_s = m_tail.pop_front();
          if (m_tail.size() == 0) m_mode = 0;
        end
        m_slot = !m_slot;
      end
      m_prev_en = tx_en;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (sym_valid !== exp_v || (exp_v && sym_out !== exp_s)) begin
      fails++;
      $display("FAIL %s cycle %0d: valid=%b sym=%b expected valid=%b sym=%b",
               cur_req, cycles, sym_valid, sym_out, exp_v, exp_s);
    end
    if (sym_valid && prev_v) begin
      fails++;
      $display("FAIL R2 cycle %0d: strobe on consecutive cycles, actual 1 expected 0", cycles);
    end
    prev_v = sym_valid;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle_for(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_en = 1'b0;
      txd = 2'($urandom);
    end
  endtask

  // mode 0: nibble k of the packet carries value k mod 16; mode 1: random
  task automatic send_pkt(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_en = 1'b1;
      if (mode == 0) txd = (i % 2 == 0) ? 2'((i / 2) % 4) : 2'(((i / 2) % 16) / 4);
      else           txd = 2'($urandom);
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    checks++;
    if (sym_valid !== 1'b0 || sym_out !== 5'b11111) begin
      fails++;
      $display("FAIL R1 in reset: valid=%b sym=%b expected 0 11111", sym_valid, sym_out);
    end
    rst_n = 1'b1;
    cur_req = "R10";
    idle_for(11);
    cur_req = "R6";
    send_pkt(40, 0);
    cur_req = "R4";
    idle_for(12);
    send_pkt(38, 1);
    cur_req = "R7";
    idle_for(10);
    cur_req = "R8";
    send_pkt(7, 1);
    idle_for(9);
    send_pkt(1, 1);
    idle_for(10);
    send_pkt(3, 1);
    cur_req = "R3";
    idle_for(7);
    send_pkt(12, 1);
    idle_for(8);
    send_pkt(12, 1);
    cur_req = "R9";
    idle_for(2);
    send_pkt(6, 1);
    idle_for(1);
    send_pkt(5, 1);
    idle_for(12);
    cur_req = "R5";
    for (int k = 0; k < 40; k++) begin
      send_pkt(1 + int'($urandom % 60), 1);
      idle_for(6 + int'($urandom % 10));
    end
    idle_for(8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule